// File: doc/BRIEF.md
# Auto-Increment Indirect Memory Port

This block lets a host reach storage that is not mapped into its own register space. The host sees a small bank of 32-bit registers. Three windows sit behind them. The first is an internal memory, reached through a read pointer, a write pointer and one data register for each direction. The second is a peripheral-register window whose address register carries a byte count. The third is a shared-register window driven by a control word that carries a command code. All three reach their targets through one synchronous back-end bus.

The memory window is built for streaming. The host loads a pointer once and then touches only the data register. Every data access moves its pointer on by one 32-bit word (4 byte addresses). The read side keeps one word fetched ahead of the pointer, so a read that finds that word answers in the cycle after it is accepted. A write that lands on the fetched-ahead word updates it in place.

Both the host port and the back-end bus use valid/ready handshakes. A host request is accepted only when `host_req_valid` and `host_req_ready` are both high. `host_req_ready` stays low while a back-end transfer is outstanding or while an earlier response has not been taken. Each accepted request produces exactly one response, writes included. The response is held, unchanged, until `host_rsp_ready` is high. On the back end, a transfer is presented with `bus_valid` and is held steady until `bus_ready`. Read data on `bus_rdata` is taken in the same cycle as that handshake.

Top module: `ind_mem_port`

## Requirements
- R1: Reset state. While `rst_n` is low and after it is released, `host_req_ready` is 1 and both `host_rsp_valid` and `bus_valid` are 0. Both memory pointers read back as 0.
- R2: Register select 0 is the memory read pointer, and reading it returns the last value written to it. Writing it starts a back-end read of memory space (`bus_space` 0) at the new address.
- R3: A read of register select 3 returns the memory word at the read pointer, then adds 4 to the pointer. If the word was already fetched ahead, the response is valid in the cycle after acceptance. If it was not (nothing fetched since reset), the response waits for a back-end read. In both cases the next word is then fetched ahead.
- R4: A write of register select 2 stores the data at the write pointer (register select 1) in memory space, then adds 4 to the write pointer.
- R5: The read pointer is independent of the write side. Writing select 1 or select 2 leaves the value read back from select 0 unchanged.
- R6: A memory write whose address equals the read pointer updates the fetched-ahead word. The next read of select 3 returns the newly written data.
- R7: A write of select 6 makes a back-end write in peripheral space (`bus_space` 1). The address is bits 15:0 of the peripheral write-address register (select 4). Byte lanes 0 to N are enabled, where N is bits 25:24 of that register (3 = full word).
- R8: A read of select 7 makes a back-end read in peripheral space at bits 15:0 of the peripheral read-address register (select 5). The response keeps only byte lanes 0 to N, with N from bits 25:24 of that register, and returns the other lanes as zero.
- R9: A write of the shared control word (select 8) with bits 29:28 equal to 3 makes a full-word back-end write in shared space (`bus_space` 2). The address is bits 15:0 of the control word and the data is the shared data register (select 9).
- R10: A control word with bits 29:28 equal to 2 makes a back-end read in shared space at bits 15:0. The result is loaded into select 9. Reading select 8 returns the control word.
- R11: A control word with bits 29:28 equal to 0 or 1 starts no back-end transfer and leaves select 9 unchanged.
- R12: Back-pressure. `host_req_ready` is low while a back-end transfer is pending. A response that is not taken stays valid with stable data and blocks new requests. A back-end request stays asserted with stable fields until `bus_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req_valid | input | 1 | Host request present |
| host_req_ready | output | 1 | Block can accept a host request |
| host_req_write | input | 1 | 1 = register write, 0 = register read |
| host_req_sel | input | 4 | Register select (0..9) |
| host_req_wdata | input | DATA_W | Host write data |
| host_rsp_valid | output | 1 | Response present |
| host_rsp_ready | input | 1 | Host takes the response |
| host_rsp_rdata | output | DATA_W | Read data (0 for writes) |
| bus_valid | output | 1 | Back-end transfer requested |
| bus_ready | input | 1 | Back-end transfer completes this cycle |
| bus_write | output | 1 | 1 = back-end write |
| bus_space | output | 2 | 0 memory, 1 peripheral, 2 shared |
| bus_addr | output | DATA_W | Back-end byte address or offset |
| bus_be | output | DATA_W/8 | Byte-lane enables |
| bus_wdata | output | DATA_W | Back-end write data |
| bus_rdata | input | DATA_W | Back-end read data, taken at handshake |

## Verification
Streams of read-data accesses after a pointer load are compared against a memory model. These tell apart a pointer that steps by one word from one that steps by one byte or does not step at all. They also tell apart a fetched-ahead hit, answered in one cycle, from a demand miss. Interleaved pointer and data writes show whether the read pointer really is independent of the write side. A write that lands on the fetched-ahead address shows whether a stale word can be returned. Window accesses use several byte counts and all four command codes, so lane masking and the no-op codes can be told apart from full transfers. Stalled back-end cycles and a held-off response check that requests wait and that outputs stay stable.

// File: rtl/ind_port_pkg.sv
package ind_port_pkg;

  typedef enum logic [3:0] {
    RG_MEM_RPTR   = 4'd0,
    RG_MEM_WPTR   = 4'd1,
    RG_MEM_WDATA  = 4'd2,
    RG_MEM_RDATA  = 4'd3,
    RG_PRPH_WADDR = 4'd4,
    RG_PRPH_RADDR = 4'd5,
    RG_PRPH_WDATA = 4'd6,
    RG_PRPH_RDATA = 4'd7,
    RG_SHR_CTRL   = 4'd8,
    RG_SHR_DATA   = 4'd9
  } reg_sel_e;

  typedef enum logic [1:0] {
    SP_MEM  = 2'd0,
    SP_PRPH = 2'd1,
    SP_SHR  = 2'd2
  } space_e;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_MEM_DEMAND,
    OP_MEM_PREFETCH,
    OP_MEM_WR,
    OP_PRPH_WR,
    OP_PRPH_RD,
    OP_SHR_WR,
    OP_SHR_RD
  } op_e;

  localparam logic [1:0] SHR_CMD_RD = 2'd2;
  localparam logic [1:0] SHR_CMD_WR = 2'd3;

endpackage

// File: rtl/ind_ptr_unit.sv
module ind_ptr_unit #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_rptr,
  input  logic          ld_wptr,
  input  logic [AW-1:0] ld_val,
  input  logic          adv_rptr,
  input  logic          adv_wptr,
  input  logic          pf_fill,
  input  logic [DW-1:0] pf_fill_data,
  input  logic          pf_drop,
  output logic [AW-1:0] rptr,
  output logic [AW-1:0] wptr,
  output logic [DW-1:0] pf_data,
  output logic          pf_valid
);

  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr <= '0;
    end else if (ld_rptr) begin
      rptr <= ld_val;
    end else if (adv_rptr) begin
      rptr <= rptr + STEP_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
    end else if (ld_wptr) begin
      wptr <= ld_val;
    end else if (adv_wptr) begin
      wptr <= wptr + STEP_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_data  <= '0;
    end else if (pf_fill) begin
      pf_valid <= 1'b1;
      pf_data  <= pf_fill_data;
    end else if (pf_drop) begin
      pf_valid <= 1'b0;
    end
  end

  // R3
  rptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_rptr && !ld_rptr |=> rptr == $past(rptr) + STEP_V);

  // R4
  wptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_wptr && !ld_wptr |=> wptr == $past(wptr) + STEP_V);

  // R5
  rptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_wptr || adv_wptr) && !ld_rptr && !adv_rptr |=> $stable(rptr));

endmodule

// File: rtl/ind_lane_mask.sv
module ind_lane_mask #(
  parameter int NB    = 4,
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] cnt,
  output logic [NB-1:0]    be
);

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign be[i] = (CNT_W'(i) <= cnt);
  end

endmodule

// File: rtl/ind_win_regs.sv
module ind_win_regs
  import ind_port_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  reg_sel_e      wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          shr_fill,
  input  logic [DW-1:0] shr_fill_data,
  output logic [DW-1:0] prph_waddr,
  output logic [DW-1:0] prph_raddr,
  output logic [DW-1:0] shr_ctrl,
  output logic [DW-1:0] shr_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prph_waddr <= '0;
      prph_raddr <= '0;
      shr_ctrl   <= '0;
    end else if (wr_en) begin
      if (wr_sel == RG_PRPH_WADDR) prph_waddr <= wr_data;
      if (wr_sel == RG_PRPH_RADDR) prph_raddr <= wr_data;
      if (wr_sel == RG_SHR_CTRL)   shr_ctrl   <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shr_data <= '0;
    end else if (shr_fill) begin
      shr_data <= shr_fill_data;
    end else if (wr_en && wr_sel == RG_SHR_DATA) begin
      shr_data <= wr_data;
    end
  end

  // R11
  shr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shr_fill && !(wr_en && wr_sel == RG_SHR_DATA) |=> $stable(shr_data));

endmodule

// File: rtl/ind_mem_port.sv
module ind_mem_port
  import ind_port_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int OFFS_W  = 16,
  parameter int CNT_LSB = 24,
  parameter int CMD_LSB = 28
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_req_valid,
  output logic                host_req_ready,
  input  logic                host_req_write,
  input  logic [3:0]          host_req_sel,
  input  logic [DATA_W-1:0]   host_req_wdata,
  output logic                host_rsp_valid,
  input  logic                host_rsp_ready,
  output logic [DATA_W-1:0]   host_rsp_rdata,
  output logic                bus_valid,
  input  logic                bus_ready,
  output logic                bus_write,
  output logic [1:0]          bus_space,
  output logic [DATA_W-1:0]   bus_addr,
  output logic [DATA_W/8-1:0] bus_be,
  output logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W-1:0]   bus_rdata
);

  localparam int NB        = DATA_W / 8;
  localparam int CNT_W     = $clog2(NB);
  localparam int WORD_STEP = NB;

  op_e                op_q, op_d;
  logic [DATA_W-1:0]  wd_q;
  logic               rsp_valid_q;
  logic [DATA_W-1:0]  rsp_data_q;

  logic               accept, done;
  reg_sel_e           sel;
  logic [1:0]         req_cmd;

  logic               ld_rptr, ld_wptr, adv_r, adv_w;
  logic               pf_fill, pf_drop;
  logic [DATA_W-1:0]  fill_data;
  logic [DATA_W-1:0]  rptr, wptr, pf_data;
  logic               pf_valid;

  logic               win_wr, shr_fill;
  logic [DATA_W-1:0]  prph_waddr, prph_raddr, shr_ctrl, shr_data;

  logic               rsp_set, wd_load;
  logic [DATA_W-1:0]  rsp_set_data;

  logic [NB-1:0]      w_be, r_be;
  logic [DATA_W-1:0]  r_mask;

  assign sel            = reg_sel_e'(host_req_sel);
  assign req_cmd        = host_req_wdata[CMD_LSB +: 2];
  assign host_req_ready = (op_q == OP_IDLE) && !rsp_valid_q;
  assign accept         = host_req_valid && host_req_ready;
  assign bus_valid      = (op_q != OP_IDLE);
  assign done           = bus_valid && bus_ready;
  assign host_rsp_valid = rsp_valid_q;
  assign host_rsp_rdata = rsp_data_q;

  ind_ptr_unit #(.AW(DATA_W), .DW(DATA_W), .STEP(WORD_STEP)) u_ptr (
    .clk          (clk),
    .rst_n        (rst_n),
    .ld_rptr      (ld_rptr),
    .ld_wptr      (ld_wptr),
    .ld_val       (host_req_wdata),
    .adv_rptr     (adv_r),
    .adv_wptr     (adv_w),
    .pf_fill      (pf_fill),
    .pf_fill_data (fill_data),
    .pf_drop      (pf_drop),
    .rptr         (rptr),
    .wptr         (wptr),
    .pf_data      (pf_data),
    .pf_valid     (pf_valid)
  );

  ind_win_regs #(.DW(DATA_W)) u_win (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (win_wr),
    .wr_sel        (sel),
    .wr_data       (host_req_wdata),
    .shr_fill      (shr_fill),
    .shr_fill_data (bus_rdata),
    .prph_waddr    (prph_waddr),
    .prph_raddr    (prph_raddr),
    .shr_ctrl      (shr_ctrl),
    .shr_data      (shr_data)
  );

  ind_lane_mask #(.NB(NB), .CNT_W(CNT_W)) u_wmask (
    .cnt (prph_waddr[CNT_LSB +: CNT_W]),
    .be  (w_be)
  );

  ind_lane_mask #(.NB(NB), .CNT_W(CNT_W)) u_rmask (
    .cnt (prph_raddr[CNT_LSB +: CNT_W]),
    .be  (r_be)
  );

  for (genvar i = 0; i < NB; i++) begin : g_rmask
    assign r_mask[8*i +: 8] = {8{r_be[i]}};
  end

  // Request decode and back-end completion handling.
  always_comb begin
    op_d         = op_q;
    ld_rptr      = 1'b0;
    ld_wptr      = 1'b0;
    adv_r        = 1'b0;
    adv_w        = 1'b0;
    pf_fill      = 1'b0;
    pf_drop      = 1'b0;
    fill_data    = bus_rdata;
    win_wr       = 1'b0;
    shr_fill     = 1'b0;
    rsp_set      = 1'b0;
    rsp_set_data = '0;
    wd_load      = 1'b0;

    if (accept) begin
      win_wr = host_req_write;
      case (sel)
        RG_MEM_RPTR: begin
          rsp_set = 1'b1;
          if (host_req_write) begin
            ld_rptr = 1'b1;
            pf_drop = 1'b1;
            op_d    = OP_MEM_PREFETCH;
          end else begin
            rsp_set_data = rptr;
          end
        end
        RG_MEM_WPTR: begin
          rsp_set = 1'b1;
          if (host_req_write) ld_wptr = 1'b1;
          else rsp_set_data = wptr;
        end
        RG_MEM_WDATA: begin
          if (host_req_write) begin
            wd_load = 1'b1;
            op_d    = OP_MEM_WR;
          end else begin
            rsp_set = 1'b1;
          end
        end
        RG_MEM_RDATA: begin
          if (host_req_write) begin
            rsp_set = 1'b1;
          end else if (pf_valid) begin
            rsp_set      = 1'b1;
            rsp_set_data = pf_data;
            adv_r        = 1'b1;
            pf_drop      = 1'b1;
            op_d         = OP_MEM_PREFETCH;
          end else begin
            op_d = OP_MEM_DEMAND;
          end
        end
        RG_PRPH_WADDR: begin
          rsp_set = 1'b1;
          if (!host_req_write) rsp_set_data = prph_waddr;
        end
        RG_PRPH_RADDR: begin
          rsp_set = 1'b1;
          if (!host_req_write) rsp_set_data = prph_raddr;
        end
        RG_PRPH_WDATA: begin
          if (host_req_write) begin
            wd_load = 1'b1;
            op_d    = OP_PRPH_WR;
          end else begin
            rsp_set = 1'b1;
          end
        end
        RG_PRPH_RDATA: begin
          if (host_req_write) rsp_set = 1'b1;
          else op_d = OP_PRPH_RD;
        end
        RG_SHR_CTRL: begin
          if (host_req_write && req_cmd == SHR_CMD_WR) begin
            op_d = OP_SHR_WR;
          end else if (host_req_write && req_cmd == SHR_CMD_RD) begin
            op_d = OP_SHR_RD;
          end else begin
            rsp_set = 1'b1;
            if (!host_req_write) rsp_set_data = shr_ctrl;
          end
        end
        RG_SHR_DATA: begin
          rsp_set = 1'b1;
          if (!host_req_write) rsp_set_data = shr_data;
        end
        default: rsp_set = 1'b1;
      endcase
    end else if (done) begin
      op_d = OP_IDLE;
      case (op_q)
        OP_MEM_PREFETCH: pf_fill = 1'b1;
        OP_MEM_DEMAND: begin
          rsp_set      = 1'b1;
          rsp_set_data = bus_rdata;
          adv_r        = 1'b1;
          op_d         = OP_MEM_PREFETCH;
        end
        OP_MEM_WR: begin
          rsp_set = 1'b1;
          adv_w   = 1'b1;
          if (wptr == rptr) begin
            pf_fill   = 1'b1;
            fill_data = wd_q;
          end
        end
        OP_PRPH_RD: begin
          rsp_set      = 1'b1;
          rsp_set_data = bus_rdata & r_mask;
        end
        OP_SHR_RD: begin
          rsp_set  = 1'b1;
          shr_fill = 1'b1;
        end
        default: rsp_set = 1'b1;
      endcase
    end
  end

  // Back-end request fields, held by the registered operation.
  always_comb begin
    bus_write = 1'b0;
    bus_space = SP_MEM;
    bus_addr  = '0;
    bus_be    = '1;
    bus_wdata = '0;
    case (op_q)
      OP_MEM_PREFETCH, OP_MEM_DEMAND: begin
        bus_addr = rptr;
      end
      OP_MEM_WR: begin
        bus_write = 1'b1;
        bus_addr  = wptr;
        bus_wdata = wd_q;
      end
      OP_PRPH_WR: begin
        bus_write = 1'b1;
        bus_space = SP_PRPH;
        bus_addr  = {{(DATA_W-OFFS_W){1'b0}}, prph_waddr[OFFS_W-1:0]};
        bus_be    = w_be;
        bus_wdata = wd_q;
      end
      OP_PRPH_RD: begin
        bus_space = SP_PRPH;
        bus_addr  = {{(DATA_W-OFFS_W){1'b0}}, prph_raddr[OFFS_W-1:0]};
        bus_be    = r_be;
      end
      OP_SHR_WR: begin
        bus_write = 1'b1;
        bus_space = SP_SHR;
        bus_addr  = {{(DATA_W-OFFS_W){1'b0}}, shr_ctrl[OFFS_W-1:0]};
        bus_wdata = shr_data;
      end
      OP_SHR_RD: begin
        bus_space = SP_SHR;
        bus_addr  = {{(DATA_W-OFFS_W){1'b0}}, shr_ctrl[OFFS_W-1:0]};
      end
      default: bus_be = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q        <= OP_IDLE;
      wd_q        <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      op_q <= op_d;
      if (wd_load) wd_q <= host_req_wdata;
      if (rsp_set) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= rsp_set_data;
      end else if (host_rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
    end
  end

  // R12
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) &&
      $stable(bus_write) && $stable(bus_space) && $stable(bus_wdata));

  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid && !host_rsp_ready |=> host_rsp_valid && $stable(host_rsp_rdata));

  // R12
  accept_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_req_valid && host_req_ready |-> !bus_valid);

  // R7
  prph_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_space == SP_PRPH |-> bus_be[0]);

  // R9
  shr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_space == SP_SHR |-> &bus_be);

endmodule

// File: tb/ind_mem_port_bench.sv
module ind_mem_port_bench;

  localparam int DW = 32;
  localparam int NB = DW / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_req_valid = 1'b0;
  logic          host_req_ready;
  logic          host_req_write = 1'b0;
  logic [3:0]    host_req_sel = 4'd0;
  logic [DW-1:0] host_req_wdata = '0;
  logic          host_rsp_valid;
  logic          host_rsp_ready = 1'b1;
  logic [DW-1:0] host_rsp_rdata;
  logic          bus_valid;
  logic          bus_ready;
  logic          bus_write;
  logic [1:0]    bus_space;
  logic [DW-1:0] bus_addr;
  logic [NB-1:0] bus_be;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ind_mem_port u_ind_mem_port (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_req_valid (host_req_valid),
    .host_req_ready (host_req_ready),
    .host_req_write (host_req_write),
    .host_req_sel   (host_req_sel),
    .host_req_wdata (host_req_wdata),
    .host_rsp_valid (host_rsp_valid),
    .host_rsp_ready (host_rsp_ready),
    .host_rsp_rdata (host_rsp_rdata),
    .bus_valid      (bus_valid),
    .bus_ready      (bus_ready),
    .bus_write      (bus_write),
    .bus_space      (bus_space),
    .bus_addr       (bus_addr),
    .bus_be         (bus_be),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata)
  );

  function automatic logic [31:0] mw(input int i);
    return 32'h1000_0000 + 32'(i) * 32'h0001_0101;
  endfunction
  function automatic logic [31:0] prv(input logic [15:0] off);
    return {off ^ 16'h5A5A, off};
  endfunction
  function automatic logic [31:0] shv(input logic [15:0] off);
    return {16'hC0DE, ~off};
  endfunction

  // Back-end model: memory, peripheral and shared spaces.
  logic [31:0] mem [64];
  int          stall_len = 0;
  int          wait_cnt = 0;
  int          xfer_cnt = 0;
  logic        last_write;
  logic [1:0]  last_space;
  logic [31:0] last_addr, last_wdata;
  logic [3:0]  last_be;

  assign bus_ready = bus_valid && (wait_cnt >= stall_len);

  always_comb begin
    case (bus_space)
      2'd0:    bus_rdata = mem[bus_addr[7:2]];
      2'd1:    bus_rdata = prv(bus_addr[15:0]);
      default: bus_rdata = shv(bus_addr[15:0]);
    endcase
  end

  always @(posedge clk) begin
    if (bus_valid && !bus_ready) wait_cnt <= wait_cnt + 1;
    else wait_cnt <= 0;
    if (bus_valid && bus_ready) begin
      xfer_cnt <= xfer_cnt + 1;
      if (bus_write) begin
        last_write <= 1'b1;
        last_space <= bus_space;
        last_addr  <= bus_addr;
        last_be    <= bus_be;
        last_wdata <= bus_wdata;
        if (bus_space == 2'd0) mem[bus_addr[7:2]] <= bus_wdata;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [3:0] sel, input logic [31:0] wd,
                      output logic [31:0] rd, output int lat);
    @(negedge clk);
    host_req_valid = 1'b1;
    host_req_write = wr;
    host_req_sel   = sel;
    host_req_wdata = wd;
    while (!host_req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    host_req_valid = 1'b0;
    lat = 0;
    while (!host_rsp_valid) begin
      @(negedge clk);
      lat++;
    end
    rd = host_rsp_rdata;
  endtask

  // Vector: {write, select, data, expected, requirement number}
  typedef logic [72:0] vec_t;
  function automatic vec_t v(input logic wr, input logic [3:0] sel, input logic [31:0] d,
                             input logic [31:0] e, input logic [3:0] r);
    return {wr, sel, d, e, r};
  endfunction

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    v(1'b1, 4'd0, 32'h10, 32'h0, 4'd2),                         // R2
    v(1'b0, 4'd0, 32'h0, 32'h10, 4'd2),                         // R2
    v(1'b0, 4'd3, 32'h0, mw(4), 4'd3),                          // R3
    v(1'b0, 4'd3, 32'h0, mw(5), 4'd3),                          // R3
    v(1'b0, 4'd3, 32'h0, mw(6), 4'd3),                          // R3
    v(1'b0, 4'd0, 32'h0, 32'h1C, 4'd3),                         // R3
    v(1'b1, 4'd1, 32'h20, 32'h0, 4'd5),                         // R5
    v(1'b0, 4'd0, 32'h0, 32'h1C, 4'd5),                         // R5
    v(1'b1, 4'd2, 32'hDEAD0001, 32'h0, 4'd4),                   // R4
    v(1'b1, 4'd2, 32'hDEAD0002, 32'h0, 4'd4),                   // R4
    v(1'b0, 4'd1, 32'h0, 32'h28, 4'd4),                         // R4
    v(1'b0, 4'd0, 32'h0, 32'h1C, 4'd5),                         // R5
    v(1'b0, 4'd3, 32'h0, mw(7), 4'd3),                          // R3
    v(1'b0, 4'd3, 32'h0, 32'hDEAD0001, 4'd4),                   // R4
    v(1'b1, 4'd1, 32'h24, 32'h0, 4'd6),                         // R6
    v(1'b1, 4'd2, 32'hBEEF0009, 32'h0, 4'd6),                   // R6
    v(1'b0, 4'd3, 32'h0, 32'hBEEF0009, 4'd6),                   // R6
    v(1'b1, 4'd5, 32'h01000123, 32'h0, 4'd8),                   // R8
    v(1'b0, 4'd7, 32'h0, prv(16'h0123) & 32'h0000FFFF, 4'd8),   // R8
    v(1'b1, 4'd5, 32'h03000040, 32'h0, 4'd8),                   // R8
    v(1'b0, 4'd7, 32'h0, prv(16'h0040), 4'd8),                  // R8
    v(1'b1, 4'd8, 32'h20000055, 32'h0, 4'd10),                  // R10
    v(1'b0, 4'd9, 32'h0, shv(16'h0055), 4'd10),                 // R10
    v(1'b0, 4'd8, 32'h0, 32'h20000055, 4'd10)                   // R10
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    int lat;
    int xc;
    for (int i = 0; i < 64; i++) mem[i] = mw(i);
    last_write = 1'b0; last_space = '0; last_addr = '0; last_be = '0; last_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      vec_t e;
      e = TBL[k];
      xfer(e[72], e[71:68], e[67:36], rd, lat);
      if (!e[72]) check($sformatf("R%0d vector %0d", e[3:0], k), rd, e[35:4]);
    end

    // R1: reset returns the block to its idle state with both pointers cleared
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R1 ready in reset", 32'(host_req_ready), 32'd1);
    check("R1 rsp_valid in reset", 32'(host_rsp_valid), 32'd0);
    check("R1 bus_valid in reset", 32'(bus_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 bus_valid after reset", 32'(bus_valid), 32'd0);
    xfer(1'b0, 4'd0, 32'h0, rd, lat);
    check("R1 read pointer after reset", rd, 32'h0);
    xfer(1'b0, 4'd1, 32'h0, rd, lat);
    check("R1 write pointer after reset", rd, 32'h0);

    // R3: demand read with nothing fetched, then a fetched-ahead hit
    xfer(1'b0, 4'd3, 32'h0, rd, lat);
    check("R3 demand data", rd, mw(0));
    check("R3 demand waits", 32'(lat > 0), 32'd1);
    xfer(1'b0, 4'd3, 32'h0, rd, lat);
    check("R3 hit data", rd, mw(1));
    check("R3 hit latency", 32'(lat), 32'd0);

    // R7: peripheral write, byte count 2 -> lanes 0..2
    xfer(1'b1, 4'd4, 32'h02000ABC, rd, lat);
    xfer(1'b1, 4'd6, 32'h11223344, rd, lat);
    check("R7 space", 32'(last_space), 32'd1);
    check("R7 addr", last_addr, 32'h0ABC);
    check("R7 byte enables", 32'(last_be), 32'h7);
    check("R7 data", last_wdata, 32'h11223344);

    // R9: shared write, command 3
    xfer(1'b1, 4'd9, 32'hCAFEF00D, rd, lat);
    xfer(1'b1, 4'd8, 32'h300001DC, rd, lat);
    check("R9 space", 32'(last_space), 32'd2);
    check("R9 addr", last_addr, 32'h01DC);
    check("R9 data", last_wdata, 32'hCAFEF00D);
    check("R9 byte enables", 32'(last_be), 32'hF);

    // R11: commands 0 and 1 start nothing and leave the data register alone
    xfer(1'b1, 4'd9, 32'h12345678, rd, lat);
    xc = xfer_cnt;
    xfer(1'b1, 4'd8, 32'h000000AA, rd, lat);
    xfer(1'b1, 4'd8, 32'h100000AB, rd, lat);
    check("R11 no transfer", 32'(xfer_cnt - xc), 32'd0);
    xfer(1'b0, 4'd9, 32'h0, rd, lat);
    check("R11 data kept", rd, 32'h12345678);

    // R12: stalled back end holds off requests
    stall_len = 3;
    xfer(1'b1, 4'd0, 32'h30, rd, lat);
    @(negedge clk);
    check("R12 bus pending", 32'(bus_valid), 32'd1);
    check("R12 ready low while pending", 32'(host_req_ready), 32'd0);
    xfer(1'b0, 4'd3, 32'h0, rd, lat);
    check("R12 data after stall", rd, mw(12));
    stall_len = 0;

    // R12: an untaken response is held and blocks requests
    repeat (6) @(negedge clk);
    host_rsp_ready = 1'b0;
    host_req_valid = 1'b1;
    host_req_write = 1'b0;
    host_req_sel   = 4'd0;
    while (!host_req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    host_req_valid = 1'b0;
    for (int n = 0; n < 3; n++) begin
      check("R12 rsp held", 32'(host_rsp_valid), 32'd1);
      check("R12 rsp data stable", host_rsp_rdata, 32'h34);
      check("R12 ready low while rsp held", 32'(host_req_ready), 32'd0);
      @(negedge clk);
    end
    host_rsp_ready = 1'b1;
    @(negedge clk);
    check("R12 rsp released", 32'(host_rsp_valid), 32'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule